// File: doc/BRIEF.md
# Battery Charge Stage Sequencer

This block chooses the charging stage of a linear battery charger without any processor involvement. It watches a digital flag that says the supply input is within its legal range, and a stream of digitised measurements: battery voltage, battery temperature and charge current. From these it decides whether the charger should be off, reviving a deeply discharged cell with a tiny current, charging gently, charging at full constant current, holding constant voltage, or resting because the cell is full. Every decision threshold is an input port, so the surrounding logic or firmware may set it.

Measurements arrive as samples marked by `smp_valid`. There is no back-pressure: the sequencer takes one sample on every cycle where `smp_valid` is high and never stalls, so it has no ready output. A threshold comparison only counts as true after `QUAL_N` consecutive samples agree. This filters ADC noise and keeps the charger from chattering between stages. An over-temperature condition moves the charger into a fault state, which it leaves only after the cell cools below a lower threshold. A software enable input can stop charging or let it run.

Top module: `chg_stage_fsm`

## Requirements
- R1: While `vbus_ok` is low, every stage except fault goes to idle on the next clock edge. A stage that is already idle stays idle.
- R2: When idle with `vbus_ok` and `chg_en` both high, the sequencer enters trickle on the next edge and drives mode 1 (trickle current).
- R3: From trickle it moves to precharge (mode 2, reduced current) once `vbat >= th_act` has been qualified.
- R4: From precharge it moves to constant current (mode 3, full current) once `vbat >= th_full` has been qualified.
- R5: From constant current it moves to constant voltage (mode 4) once `vbat >= th_cv` has been qualified. From constant voltage it moves to done (mode 0, `chg_done` = 1) once `ichg <= th_term` has been qualified.
- R6: In done, a qualified `vbat < th_rechg` returns the sequencer to constant voltage, and `chg_done` clears. A voltage at or above `th_rechg` leaves it in done.
- R7: In any stage other than fault, a qualified `temp >= th_hot` enters fault (mode 0). Fault ignores `vbus_ok` and `chg_en`. It is left for idle only after `temp < th_cool` has been qualified. A temperature between the two thresholds keeps the sequencer in fault.
- R8: A comparison is qualified only after `QUAL_N` consecutive valid samples satisfy it. A sample that fails the comparison restarts the count. Every stage change also restarts all counts.
- R9: With `chg_en` low, every stage except fault goes to idle, and the sequencer stays in idle whatever the samples say.
- R10: `stage` codes are idle 0, trickle 1, precharge 2, constant current 3, constant voltage 4, done 5, fault 6. Code 7 never appears. `mode` is 0 in idle, done and fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chg_en | input | 1 | Software charge enable |
| vbus_ok | input | 1 | Supply input within its legal range |
| smp_valid | input | 1 | Marks a new measurement sample |
| vbat | input | W | Battery voltage sample |
| temp | input | W | Battery temperature sample |
| ichg | input | W | Charge current sample |
| th_act | input | W | Activation threshold (trickle to precharge) |
| th_full | input | W | Full-current threshold |
| th_cv | input | W | Constant-voltage threshold |
| th_rechg | input | W | Recharge threshold |
| th_term | input | W | Termination current |
| th_hot | input | W | Over-temperature entry threshold |
| th_cool | input | W | Over-temperature release threshold |
| stage | output | 3 | Stage code |
| mode | output | 3 | Current-level select |
| chg_done | output | 1 | Charging complete |

## Verification
The assertions check on every cycle that stage codes stay legal, that each stage can only step to its allowed successors, and that supply loss or a software stop forces idle unless a fault is held. Only the bench scenarios can show the things that depend on data: the threshold values at which each transition fires, that a broken run of samples does not advance the stage, the hysteresis band of the temperature fault, and re-entry from done into constant voltage.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TRKL  = 3'd1,
    ST_PRE   = 3'd2,
    ST_CC    = 3'd3,
    ST_CV    = 3'd4,
    ST_DONE  = 3'd5,
    ST_FAULT = 3'd6
  } stage_e;

  typedef enum logic [2:0] {
    MD_OFF  = 3'd0,
    MD_TRKL = 3'd1,
    MD_LOW  = 3'd2,
    MD_FULL = 3'd3,
    MD_CV   = 3'd4
  } mode_e;

  localparam int C_ACT   = 0;
  localparam int C_FULL  = 1;
  localparam int C_CV    = 2;
  localparam int C_TERM  = 3;
  localparam int C_RECHG = 4;
  localparam int C_HOT   = 5;
  localparam int C_COOL  = 6;
  localparam int NCOND   = 7;
endpackage

// File: rtl/chg_cmp.sv
module chg_cmp
  import chg_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0]     vbat,
  input  logic [W-1:0]     temp,
  input  logic [W-1:0]     ichg,
  input  logic [W-1:0]     th_act,
  input  logic [W-1:0]     th_full,
  input  logic [W-1:0]     th_cv,
  input  logic [W-1:0]     th_rechg,
  input  logic [W-1:0]     th_term,
  input  logic [W-1:0]     th_hot,
  input  logic [W-1:0]     th_cool,
  output logic [NCOND-1:0] raw
);
  always_comb begin
    raw          = '0;
    raw[C_ACT]   = (vbat >= th_act);
    raw[C_FULL]  = (vbat >= th_full);
    raw[C_CV]    = (vbat >= th_cv);
    raw[C_TERM]  = (ichg <= th_term);
    raw[C_RECHG] = (vbat <  th_rechg);
    raw[C_HOT]   = (temp >= th_hot);
    raw[C_COOL]  = (temp <  th_cool);
  end
endmodule

// File: rtl/chg_qual.sv
module chg_qual
  import chg_pkg::*;
#(
  parameter int QUAL_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_valid,
  input  logic [NCOND-1:0] raw,
  output logic [NCOND-1:0] held
);
  localparam int CW = $clog2(QUAL_N + 1);
  localparam logic [CW-1:0] CMAX = CW'(QUAL_N);

  for (genvar g = 0; g < NCOND; g++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (smp_valid) begin
        if (!raw[g])           cnt <= '0;
        else if (cnt != CMAX)  cnt <= cnt + 1'b1;
      end
    end
    assign held[g] = (cnt == CMAX);
  end
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_en,
  input  logic             vbus_ok,
  input  logic [NCOND-1:0] held,
  output stage_e           st,
  output logic             clr
);
  stage_e nxt;

  always_comb begin
    nxt = st;
    if (st == ST_FAULT) begin
      if (held[C_COOL]) nxt = ST_IDLE;
    end else if (held[C_HOT]) begin
      nxt = ST_FAULT;
    end else if (!(vbus_ok && chg_en)) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: nxt = ST_TRKL;
        ST_TRKL: if (held[C_ACT])   nxt = ST_PRE;
        ST_PRE:  if (held[C_FULL])  nxt = ST_CC;
        ST_CC:   if (held[C_CV])    nxt = ST_CV;
        ST_CV:   if (held[C_TERM])  nxt = ST_DONE;
        ST_DONE: if (held[C_RECHG]) nxt = ST_CV;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  assign clr = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end
endmodule

// File: rtl/chg_out.sv
module chg_out
  import chg_pkg::*;
(
  input  stage_e      st,
  output logic [2:0]  stage,
  output logic [2:0]  mode,
  output logic        chg_done
);
  mode_e md;
  always_comb begin
    case (st)
      ST_TRKL: md = MD_TRKL;
      ST_PRE:  md = MD_LOW;
      ST_CC:   md = MD_FULL;
      ST_CV:   md = MD_CV;
      default: md = MD_OFF;
    endcase
  end
  assign stage    = st;
  assign mode     = md;
  assign chg_done = (st == ST_DONE);
endmodule

// File: rtl/chg_stage_fsm.sv
module chg_stage_fsm
  import chg_pkg::*;
#(
  parameter int W      = 10,
  parameter int QUAL_N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chg_en,
  input  logic         vbus_ok,
  input  logic         smp_valid,
  input  logic [W-1:0] vbat,
  input  logic [W-1:0] temp,
  input  logic [W-1:0] ichg,
  input  logic [W-1:0] th_act,
  input  logic [W-1:0] th_full,
  input  logic [W-1:0] th_cv,
  input  logic [W-1:0] th_rechg,
  input  logic [W-1:0] th_term,
  input  logic [W-1:0] th_hot,
  input  logic [W-1:0] th_cool,
  output logic [2:0]   stage,
  output logic [2:0]   mode,
  output logic         chg_done
);
  logic [NCOND-1:0] raw;
  logic [NCOND-1:0] held;
  logic             clr;
  stage_e           st;

  chg_cmp #(.W(W)) u_cmp (
    .vbat(vbat), .temp(temp), .ichg(ichg),
    .th_act(th_act), .th_full(th_full), .th_cv(th_cv),
    .th_rechg(th_rechg), .th_term(th_term),
    .th_hot(th_hot), .th_cool(th_cool),
    .raw(raw)
  );

  chg_qual #(.QUAL_N(QUAL_N)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .smp_valid(smp_valid), .raw(raw), .held(held)
  );

  chg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .vbus_ok(vbus_ok),
    .held(held), .st(st), .clr(clr)
  );

  chg_out u_out (
    .st(st), .stage(stage), .mode(mode), .chg_done(chg_done)
  );
endmodule

// File: rtl/chg_stage_fsm_chk.sv
module chg_stage_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chg_en,
  input logic       vbus_ok,
  input logic [2:0] stage
);
  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 3'd7);

  // R1
  supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbus_ok && stage != 3'd6) |=> (stage == 3'd0 || stage == 3'd6));

  // R9
  sw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_en && stage != 3'd6) |=> (stage == 3'd0 || stage == 3'd6));

  // R7
  fault_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd6) |=> (stage == 3'd6 || stage == 3'd0));

  // R3
  trickle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd1) |=> (stage == 3'd1 || stage == 3'd2 || stage == 3'd0 || stage == 3'd6));

  // R4
  pre_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd2) |=> (stage == 3'd2 || stage == 3'd3 || stage == 3'd0 || stage == 3'd6));

  // R5
  cc_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd3) |=> (stage == 3'd3 || stage == 3'd4 || stage == 3'd0 || stage == 3'd6));

  // R6
  done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd5) |=> (stage == 3'd5 || stage == 3'd4 || stage == 3'd0 || stage == 3'd6));
endmodule

bind chg_stage_fsm chg_stage_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .vbus_ok(vbus_ok), .stage(stage)
);

// File: tb/chg_stage_fsm_test.sv
module chg_stage_fsm_test;
  localparam int W = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chg_en = 1'b0;
  logic         vbus_ok = 1'b0;
  logic         smp_valid = 1'b0;
  logic [W-1:0] vbat = '0, temp = '0, ichg = '0;
  logic [W-1:0] th_act = 10'd300, th_full = 10'd500, th_cv = 10'd800;
  logic [W-1:0] th_rechg = 10'd760, th_term = 10'd50;
  logic [W-1:0] th_hot = 10'd700, th_cool = 10'd600;
  logic [2:0]   stage, mode;
  logic         chg_done;

  always #10 clk = ~clk;

  chg_stage_fsm #(.W(W), .QUAL_N(N)) uut (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .vbus_ok(vbus_ok),
    .smp_valid(smp_valid), .vbat(vbat), .temp(temp), .ichg(ichg),
    .th_act(th_act), .th_full(th_full), .th_cv(th_cv),
    .th_rechg(th_rechg), .th_term(th_term),
    .th_hot(th_hot), .th_cool(th_cool),
    .stage(stage), .mode(mode), .chg_done(chg_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  event       chk_ev;

  // driver side: push an expected {stage, mode, done}
  task automatic expect_out(input logic [2:0] s, input logic [2:0] m,
                            input logic d, input string tag);
    exp_q.push_back({s, m, d});
    tag_q.push_back(tag);
    ->chk_ev;
    @(negedge clk);
  endtask

  task automatic apply(input int v, input int t, input int i, input int n);
    @(negedge clk);
    vbat = W'(v); temp = W'(t); ichg = W'(i);
    smp_valid = 1'b1;
    repeat (n) @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor side: pop and compare
  initial begin
    forever begin
      @(chk_ev);
      #1;
      begin
        logic [6:0] e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        n_chk++;
        if ({stage, mode, chg_done} !== e) begin
          n_bad++;
          $display("FAIL %s: stage=%0d mode=%0d done=%0b expected stage=%0d mode=%0d done=%0b",
                   tg, stage, mode, chg_done, e[6:4], e[3:1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    temp = 10'd400; ichg = 10'd200;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(3'd0, 3'd0, 1'b0, "R1 R10 reset idle");

    vbus_ok = 1'b1;
    apply(200, 400, 200, 6);
    expect_out(3'd0, 3'd0, 1'b0, "R9 disabled stays idle");

    vbus_ok = 1'b0; chg_en = 1'b1;
    apply(200, 400, 200, 6);
    expect_out(3'd0, 3'd0, 1'b0, "R1 no supply stays idle");

    vbus_ok = 1'b1;
    apply(200, 400, 200, 6);
    expect_out(3'd1, 3'd1, 1'b0, "R2 trickle");

    apply(400, 400, 200, N-1);
    expect_out(3'd1, 3'd1, 1'b0, "R8 short run held back");
    apply(400, 400, 200, 1);
    expect_out(3'd2, 3'd2, 1'b0, "R3 precharge");

    apply(600, 400, 200, 2);
    apply(300, 400, 200, 1);
    apply(600, 400, 200, N-1);
    expect_out(3'd2, 3'd2, 1'b0, "R8 broken run restarts");
    apply(600, 400, 200, 1);
    expect_out(3'd3, 3'd3, 1'b0, "R4 constant current");

    apply(850, 400, 200, N);
    expect_out(3'd4, 3'd4, 1'b0, "R5 constant voltage");
    apply(850, 400, 30, N);
    expect_out(3'd5, 3'd0, 1'b1, "R5 done");

    apply(780, 400, 30, 6);
    expect_out(3'd5, 3'd0, 1'b1, "R6 above recharge stays done");
    apply(700, 400, 200, N);
    expect_out(3'd4, 3'd4, 1'b0, "R6 recharge into cv");

    apply(700, 750, 200, N);
    expect_out(3'd6, 3'd0, 1'b0, "R7 fault entry");
    vbus_ok = 1'b0;
    apply(700, 650, 200, 6);
    expect_out(3'd6, 3'd0, 1'b0, "R7 hysteresis band and supply loss");
    vbus_ok = 1'b1;
    apply(700, 550, 200, N);
    expect_out(3'd1, 3'd1, 1'b0, "R7 release via idle to trickle");

    chg_en = 1'b0;
    @(negedge clk);
    expect_out(3'd0, 3'd0, 1'b0, "R9 software stop");

    vbus_ok = 1'b0;
    apply(200, 400, 200, 2);
    expect_out(3'd0, 3'd0, 1'b0, "R1 R10 idle mode off");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule